// File: doc/BRIEF.md
# Single-Level Page Table Lookup Unit

This unit turns a 32-bit virtual address into a 30-bit physical address by consulting a one-level page table kept in an internal memory. The upper 20 bits of the virtual address form the virtual page number. The lower 12 bits are the offset within a 4096-byte page. The page number, added to a table base register, selects one table entry. Each entry holds a valid bit and an 18-bit physical page number.

A lookup is requested with a one-cycle strobe. Exactly one cycle later the unit answers. The answer is either the physical address (the entry's page number joined to the untouched offset) or a page fault flag, and never both. A fault is raised when the selected entry is not marked present.

A separate write port loads table entries and may be used in the same cycle as a lookup. The table depth is a parameter. The full architectural depth of 2^20 entries is reduced here so that the table can be simulated. The base register is loaded through its own strobe.

Top module: `pt_lookup_unit`

## Requirements
- R1: After reset, no response is flagged, the base register is zero and every table entry reads as not present, so any lookup faults.
- R2: `resp_valid` is high in the cycle right after each cycle with `req_valid` high, and low otherwise. Back-to-back requests produce back-to-back responses. While `resp_valid` is low, `resp_fault` is low and `resp_paddr` is zero.
- R3: When the selected entry is present, `resp_fault` is low and `resp_paddr` equals {entry page number, request bits 11:0}, with the page number in bits 29:12.
- R4: When the selected entry is not present, `resp_fault` is high and `resp_paddr` is all zeros.
- R5: The entry index is (virtual page number + base) modulo the table depth, where the virtual page number is request bits 31:12. Page number bits at or above the index width only take part through this wrap.
- R6: A table write and a lookup of the same index in the same cycle return the entry contents from before the write. A lookup in a later cycle sees the new contents.
- R7: A base load takes effect for requests in the cycles after the load. A request in the same cycle as the load uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| base_load | input | 1 | Load strobe for the table base register |
| base_value | input | IDX_W | New table base |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W | Entry index to write |
| tbl_wr_present | input | 1 | Present bit to store |
| tbl_wr_ppn | input | PPN_W (18) | Physical page number to store |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W (32) | Virtual address to translate |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_fault | output | 1 | Page fault flag |
| resp_paddr | output | PA_W (30) | Translated physical address, zero on fault |

## Verification
The bench builds the unit with a 6-bit table index, which gives 64 entries. At that size it can sweep every entry in a single pass: first after reset, then after loading a mixed present/absent pattern, and again under a nonzero base. It uses virtual page numbers whose upper bits are nonzero, so the wrap of the index and the pass-through of varied offsets are visible. The small depth also makes it cheap to hit the same-cycle write/lookup collision and the same-cycle base reload at chosen indices, and to run long back-to-back request trains.

// File: rtl/pt_pkg.sv
// Package: shared default widths for the page table lookup unit.
// Assumes byte-addressed virtual memory with power-of-two pages.
package pt_pkg;
    localparam int PT_VA_W  = 32;  // virtual address width
    localparam int PT_OFF_W = 12;  // page offset width (4096-byte pages)
    localparam int PT_PPN_W = 18;  // physical page number width
    localparam int PT_IDX_W = 8;   // default table index width (reduced depth)
endpackage

// File: rtl/pt_addr_split.sv
// Module: pt_addr_split
// Splits a virtual address into page number and offset, and forms the
// table index as (page number + base) modulo the table depth.
// Assumes IDX_W <= VA_W - OFF_W.
module pt_addr_split #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 8
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [IDX_W-1:0] base,
    output logic [IDX_W-1:0] idx,
    output logic [OFF_W-1:0] offset
);
    localparam int VPN_W = VA_W - OFF_W;

    logic [VPN_W-1:0] vpn;

    // Separate the page number from the offset.
    always_comb begin
        vpn    = vaddr[VA_W-1:OFF_W];
        offset = vaddr[OFF_W-1:0];
    end

    // Add the base; the sum wraps at the table depth.
    always_comb begin
        idx = vpn[IDX_W-1:0] + base;
    end

    // Page number bits above the index width do not reach the table.
    generate
        if (IDX_W < VPN_W) begin : g_hi_bits
            logic unused_vpn_hi;
            assign unused_vpn_hi = ^vpn[VPN_W-1:IDX_W];
        end
    endgenerate
endmodule

// File: rtl/pt_table_mem.sv
// Module: pt_table_mem
// Page table storage: one present bit and one page number per entry.
// Present bits are cleared by reset; page numbers are not reset.
// Reads are registered and return the contents from before a write to
// the same index in the same cycle.
module pt_table_mem #(
    parameter int IDX_W = 8,
    parameter int PPN_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_present,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_present,
    output logic [PPN_W-1:0] rd_ppn
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] present_q;
    logic [PPN_W-1:0] ppn_mem [DEPTH];

    // Present bits, one flop per entry, cleared on reset.
    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_present
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    present_q[e] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                    present_q[e] <= wr_present;
                end
            end
        end
    endgenerate

    // Page number storage write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ppn_mem[wr_idx] <= wr_ppn;
        end
    end

    // Registered read; sees state from before this cycle's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_present <= 1'b0;
            rd_ppn     <= '0;
        end else if (rd_en) begin
            rd_present <= present_q[rd_idx];
            rd_ppn     <= ppn_mem[rd_idx];
        end
    end
endmodule

// File: rtl/pt_resp_stage.sv
// Module: pt_resp_stage
// Holds the request strobe and page offset for one cycle and combines
// them with the table read into the response. The address and the fault
// flag are mutually exclusive, and both are quiet when no response is due.
module pt_resp_stage #(
    parameter int OFF_W = 12,
    parameter int PPN_W = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [OFF_W-1:0]       req_offset,
    input  logic                   rd_present,
    input  logic [PPN_W-1:0]       rd_ppn,
    output logic                   resp_valid,
    output logic                   resp_fault,
    output logic [PPN_W+OFF_W-1:0] resp_paddr
);
    logic [OFF_W-1:0] offset_q;

    // Delay the strobe and offset to line up with the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            offset_q   <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                offset_q <= req_offset;
            end
        end
    end

    // Form the fault flag or the physical address, never both.
    always_comb begin
        resp_fault = resp_valid && !rd_present;
        resp_paddr = (resp_valid && rd_present) ? {rd_ppn, offset_q} : '0;
    end
endmodule

// File: rtl/pt_lookup_unit.sv
// Module: pt_lookup_unit (top)
// Single-level page table lookup: base register, index formation,
// table storage with a load port, and a fixed one-cycle response.
// Assumes IDX_W <= VA_W - OFF_W and that requests carry no back-pressure.
module pt_lookup_unit #(
    parameter int VA_W  = pt_pkg::PT_VA_W,
    parameter int OFF_W = pt_pkg::PT_OFF_W,
    parameter int PPN_W = pt_pkg::PT_PPN_W,
    parameter int IDX_W = pt_pkg::PT_IDX_W,
    localparam int PA_W = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_load,
    input  logic [IDX_W-1:0] base_value,
    input  logic             tbl_wr_en,
    input  logic [IDX_W-1:0] tbl_wr_idx,
    input  logic             tbl_wr_present,
    input  logic [PPN_W-1:0] tbl_wr_ppn,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             resp_valid,
    output logic             resp_fault,
    output logic [PA_W-1:0]  resp_paddr
);
    logic [IDX_W-1:0] base_q;
    logic [IDX_W-1:0] lookup_idx;
    logic [OFF_W-1:0] lookup_off;
    logic             rd_present;
    logic [PPN_W-1:0] rd_ppn;

    // Table base register; a load applies to later requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_load) begin
            base_q <= base_value;
        end
    end

    pt_addr_split #(
        .VA_W (VA_W),
        .OFF_W(OFF_W),
        .IDX_W(IDX_W)
    ) split_i (
        .vaddr (req_vaddr),
        .base  (base_q),
        .idx   (lookup_idx),
        .offset(lookup_off)
    );

    pt_table_mem #(
        .IDX_W(IDX_W),
        .PPN_W(PPN_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_wr_en),
        .wr_idx    (tbl_wr_idx),
        .wr_present(tbl_wr_present),
        .wr_ppn    (tbl_wr_ppn),
        .rd_en     (req_valid),
        .rd_idx    (lookup_idx),
        .rd_present(rd_present),
        .rd_ppn    (rd_ppn)
    );

    pt_resp_stage #(
        .OFF_W(OFF_W),
        .PPN_W(PPN_W)
    ) resp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_offset(lookup_off),
        .rd_present(rd_present),
        .rd_ppn    (rd_ppn),
        .resp_valid(resp_valid),
        .resp_fault(resp_fault),
        .resp_paddr(resp_paddr)
    );
endmodule

// File: rtl/pt_lookup_checker.sv
// Module: pt_lookup_checker
// Port-level properties of pt_lookup_unit, attached by bind below.
module pt_lookup_checker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PA_W  = 30
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            resp_valid,
    input logic            resp_fault,
    input logic [PA_W-1:0] resp_paddr
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !resp_valid); // R1
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R2
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R2
    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (!resp_fault && resp_paddr == '0)); // R2
    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid ##1 !resp_fault) |-> resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])); // R3
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_valid && resp_paddr == '0)); // R4
endmodule

bind pt_lookup_unit pt_lookup_checker #(
    .VA_W (VA_W),
    .OFF_W(OFF_W),
    .PA_W (PA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .resp_valid(resp_valid),
    .resp_fault(resp_fault),
    .resp_paddr(resp_paddr)
);

// File: tb/pt_lookup_unit_tb_top.sv
// Bench: sweeps a 64-entry table with arithmetic expected values.
module pt_lookup_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 6;
    localparam int DEPTH = 1 << IDX_W;
    localparam int PPN_W = 18;
    localparam int PA_W  = 30;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             base_load = 1'b0;
    logic [IDX_W-1:0] base_value = '0;
    logic             tbl_wr_en = 1'b0;
    logic [IDX_W-1:0] tbl_wr_idx = '0;
    logic             tbl_wr_present = 1'b0;
    logic [PPN_W-1:0] tbl_wr_ppn = '0;
    logic             req_valid = 1'b0;
    logic [31:0]      req_vaddr = '0;
    logic             resp_valid;
    logic             resp_fault;
    logic [PA_W-1:0]  resp_paddr;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    logic             m_present [DEPTH];
    logic [PPN_W-1:0] m_ppn     [DEPTH];
    int               m_base = 0;

    pt_lookup_unit #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .base_load(base_load), .base_value(base_value),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_present(tbl_wr_present), .tbl_wr_ppn(tbl_wr_ppn),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles > 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual cycles=%0d expected under 100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [PPN_W-1:0] pat_ppn(int i, int salt);
        return PPN_W'((i * 2731 + salt * 977 + 5) & 32'h3FFFF);
    endfunction

    // Compare one response sample against expectations.
    task automatic check_resp(string req, logic ev, logic ef, logic [PA_W-1:0] ep);
        total++;
        if (resp_valid !== ev || resp_fault !== ef || resp_paddr !== ep) begin
            bad++;
            $display("FAIL %s: actual v=%0b f=%0b pa=%h expected v=%0b f=%0b pa=%h",
                     req, resp_valid, resp_fault, resp_paddr, ev, ef, ep);
        end
    endtask

    // Expected response for a virtual address with the given base.
    task automatic expect_for(string req, logic [31:0] va, int base);
        int idx;
        idx = (int'(va[12 +: IDX_W]) + base) % DEPTH;
        if (m_present[idx])
            check_resp(req, 1'b1, 1'b0, {m_ppn[idx], va[11:0]});
        else
            check_resp(req, 1'b1, 1'b1, '0);
    endtask

    task automatic write_entry(int idx, logic pr, logic [PPN_W-1:0] ppn);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = IDX_W'(idx);
        tbl_wr_present = pr; tbl_wr_ppn = ppn;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        m_present[idx] = pr; m_ppn[idx] = ppn;
    endtask

    task automatic set_base(int b);
        @(negedge clk);
        base_load = 1'b1; base_value = IDX_W'(b);
        @(negedge clk);
        base_load = 1'b0;
        m_base = b;
    endtask

    // One isolated lookup, checked one cycle later.
    task automatic lookup(string req, logic [31:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        expect_for(req, va, m_base);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_present[i] = 1'b0; m_ppn[i] = '0;
        end
        repeat (3) @(negedge clk);
        check_resp("R1 reset outputs", 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_resp("R1 idle after reset", 1'b0, 1'b0, '0);

        // R1: every entry faults after reset.
        for (int i = 0; i < DEPTH; i++)
            lookup("R1 empty table", {20'(i), 12'(i * 37)});

        // Load a mixed pattern: every third entry absent.
        for (int i = 0; i < DEPTH; i++)
            write_entry(i, (i % 3) != 0, pat_ppn(i, 0));

        // R3 R4 R5: sweep with upper page bits set and varied offsets.
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < DEPTH; i++)
                lookup("R3 R4 R5 sweep base 0", {20'(i + (k * 4099 << IDX_W)), 12'(i * 61 + k * 1000)});

        // R5: nonzero base wraps the index.
        set_base(45);
        for (int i = 0; i < DEPTH; i++)
            lookup("R5 sweep base 45", {20'(i + (7 << IDX_W)), 12'(4095 - i)});

        // R2: back-to-back requests, responses on consecutive cycles.
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = {20'd1, 12'hABC};
        for (int i = 2; i < 40; i++) begin
            logic [31:0] prev;
            prev = req_vaddr;
            @(negedge clk);
            req_vaddr = {20'(i * 5), 12'(i * 99)};
            expect_for("R2 back-to-back", prev, m_base);
        end
        begin
            logic [31:0] last;
            last = req_vaddr;
            @(negedge clk);
            req_valid = 1'b0;
            expect_for("R2 back-to-back last", last, m_base);
        end
        @(negedge clk);
        check_resp("R2 quiet after train", 1'b0, 1'b0, '0);

        // R6: write and lookup of the same index in one cycle.
        for (int j = 0; j < 8; j++) begin
            int idx;
            logic [31:0] va;
            idx = (j * 9 + 2) % DEPTH;
            va = {20'((idx - m_base + DEPTH) % DEPTH), 12'(j * 300)};
            @(negedge clk);
            tbl_wr_en = 1'b1; tbl_wr_idx = IDX_W'(idx);
            tbl_wr_present = ~m_present[idx]; tbl_wr_ppn = pat_ppn(idx, j + 1);
            req_valid = 1'b1; req_vaddr = va;
            @(negedge clk);
            tbl_wr_en = 1'b0; req_valid = 1'b0;
            expect_for("R6 collision returns old", va, m_base);
            m_present[idx] = tbl_wr_present; m_ppn[idx] = tbl_wr_ppn;
            lookup("R6 later lookup sees new", va);
        end

        // R7: base load and request in the same cycle use the old base.
        for (int j = 0; j < 4; j++) begin
            logic [31:0] va;
            int nb;
            va = {20'(j * 13 + 3), 12'(j * 77)};
            nb = (m_base + 17 + j) % DEPTH;
            @(negedge clk);
            base_load = 1'b1; base_value = IDX_W'(nb);
            req_valid = 1'b1; req_vaddr = va;
            @(negedge clk);
            base_load = 1'b0; req_valid = 1'b0;
            expect_for("R7 same-cycle old base", va, m_base);
            m_base = nb;
            lookup("R7 next request new base", va);
        end

        @(negedge clk);
        check_resp("R2 final idle", 1'b0, 1'b0, '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule